// File: doc/BRIEF.md
# Edge-Selectable Timer Count Source

This block decides, on every system clock, whether a timer's prescale counter and its main count advance. A 2-bit mode field picks the source. In internal mode every clock feeds a prescaler that wraps at a programmable limit and advances the main count once per wrap. In the three external modes the prescaler is held at zero and the main count steps on the rising, the falling or both edges of an external pin, after that pin has been brought into the clock domain.

A 2-bit source select chooses the external pin. Only code 0 is wired, to the single pin input. The other three codes are reserved and behave as a pin held low. A 3-bit capture-control field for the chosen pin must be zero while an external mode is active. A combinational flag reports any other value so that the surrounding timer can reject the setting.

The edge detector is a two-state machine that tracks the synchronized pin level. State `LVL_LOW` moves to `LVL_HIGH` when the synchronized level reads 1. That transition raises a rise event. State `LVL_HIGH` moves to `LVL_LOW` when the level reads 0, and that transition raises a fall event. In all other cases each state holds. The decoded mode (`SRC_TIMER`, `SRC_RISE`, `SRC_FALL`, `SRC_BOTH`) selects which events step the counters.

Top module: `tcs_count_source`

## Requirements
- R1: While reset is asserted the prescale count, the main count and the state machine return to zero and `LVL_LOW`. With mode 00 the error flag reads 0.
- R2: In mode 00, while the prescale count is below the limit, each clock adds 1 to the prescale count and leaves the main count unchanged.
- R3: In mode 00, a clock that finds the prescale count equal to the limit returns it to 0 and adds 1 to the main count. A limit of 0 therefore advances the main count on every clock.
- R4: Mode 01 adds 1 to the main count for each 0-to-1 change of the selected pin. The new value appears on the third rising clock edge after the change, because two synchronizer stages and the edge detector lie on the path.
- R5: Mode 10 adds 1 to the main count for each 1-to-0 change of the selected pin.
- R6: Mode 11 adds 1 to the main count for every change of the selected pin in either direction.
- R7: In modes 01, 10 and 11 the prescale count is held at 0.
- R8: A high pulse that lasts two clock periods is counted once in mode 01, and twice in mode 11.
- R9: In the external modes, source select codes 1, 2 and 3 count nothing, whatever the pin does.
- R10: The error flag is 1 exactly when the mode is not 00 and the capture-control field is not 000.
- R11: In mode 00 the pin and the source select have no effect on either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Count source: 00 internal, 01 rise, 10 fall, 11 both |
| in_sel_i | input | 2 | External pin select: 0 pin, 1 to 3 reserved |
| cap_ctrl_i | input | 3 | Capture-control bits of the chosen pin |
| prescale_lim_i | input | PC_W | Prescale wrap value for mode 00 |
| cap_pin_i | input | 1 | Raw asynchronous external pin |
| pc_o | output | PC_W | Prescale count |
| tc_o | output | TC_W | Main count |
| cfg_err_o | output | 1 | Illegal capture configuration flag |

## Verification
The hardest case to reach from the ports is the exact cycle in which an external edge reaches the main count. The edge has to cross two synchronizer stages and the level-tracking state machine, and none of these can be seen from outside. The bench changes the pin at a falling clock edge. It then checks that the main count still holds its old value after two rising edges and has advanced after the third. It also drives short two-period pulses in the both-edge mode, so that every transition takes the state machine through both of its transitions.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic [1:0] {
        SRC_TIMER = 2'b00,
        SRC_RISE  = 2'b01,
        SRC_FALL  = 2'b10,
        SRC_BOTH  = 2'b11
    } count_src_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pin_lvl_e;

    localparam logic [1:0] SEL_PIN0 = 2'd0;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcs_edge_fsm.sv
module tcs_edge_fsm
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    pin_lvl_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (lvl_i) begin
                    state_d = LVL_HIGH;
                    rise_o  = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!lvl_i) begin
                    state_d = LVL_LOW;
                    fall_o  = 1'b1;
                end
            end
        endcase
    end

    // R6: a single clock never reports both edge kinds
    assert_edge_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/tcs_counters.sv
module tcs_counters
    import tcs_pkg::*;
#(
    parameter int PC_W = 8,
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  count_src_e      src_i,
    input  logic            rise_i,
    input  logic            fall_i,
    input  logic [PC_W-1:0] lim_i,
    output logic [PC_W-1:0] pc_o,
    output logic [TC_W-1:0] tc_o
);
    logic            ext_step;
    logic            wrap;
    logic [PC_W-1:0] pc_d;
    logic [TC_W-1:0] tc_d;

    always_comb begin
        unique case (src_i)
            SRC_TIMER: ext_step = 1'b0;
            SRC_RISE:  ext_step = rise_i;
            SRC_FALL:  ext_step = fall_i;
            SRC_BOTH:  ext_step = rise_i | fall_i;
        endcase
        wrap = (pc_o == lim_i);
        pc_d = pc_o;
        tc_d = tc_o;
        if (src_i == SRC_TIMER) begin
            if (wrap) begin
                pc_d = '0;
                tc_d = tc_o + 1'b1;
            end else begin
                pc_d = pc_o + 1'b1;
            end
        end else begin
            pc_d = '0;
            if (ext_step) tc_d = tc_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= '0;
            tc_o <= '0;
        end else begin
            pc_o <= pc_d;
            tc_o <= tc_d;
        end
    end

    assert_prescale_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == SRC_TIMER && pc_o != lim_i) |=>
            (pc_o == $past(pc_o) + 1'b1 && tc_o == $past(tc_o)));

    assert_prescale_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == SRC_TIMER && pc_o == lim_i) |=>
            (pc_o == '0 && tc_o == $past(tc_o) + 1'b1));

    assert_ext_pc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != SRC_TIMER) |=> (pc_o == '0));

    // R4: an external mode never advances the main count by more than one
    assert_ext_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != SRC_TIMER) |=> (tc_o == $past(tc_o) || tc_o == $past(tc_o) + 1'b1));
endmodule

// File: rtl/tcs_count_source.sv
module tcs_count_source
    import tcs_pkg::*;
#(
    parameter int PC_W      = 8,
    parameter int TC_W      = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic [1:0]      in_sel_i,
    input  logic [2:0]      cap_ctrl_i,
    input  logic [PC_W-1:0] prescale_lim_i,
    input  logic            cap_pin_i,
    output logic [PC_W-1:0] pc_o,
    output logic [TC_W-1:0] tc_o,
    output logic            cfg_err_o
);
    count_src_e src;
    logic       pin_gated;
    logic       pin_sync;
    logic       rise;
    logic       fall;

    assign src       = count_src_e'(mode_i);
    // reserved selects read as a constant low pin
    assign pin_gated = (in_sel_i == SEL_PIN0) ? cap_pin_i : 1'b0;
    assign cfg_err_o = (src != SRC_TIMER) && (cap_ctrl_i != 3'b000);

    tcs_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_gated),
        .sync_o  (pin_sync)
    );

    tcs_edge_fsm u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_sync),
        .rise_o (rise),
        .fall_o (fall)
    );

    tcs_counters #(.PC_W(PC_W), .TC_W(TC_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src),
        .rise_i (rise),
        .fall_i (fall),
        .lim_i  (prescale_lim_i),
        .pc_o   (pc_o),
        .tc_o   (tc_o)
    );

    // R9: with a reserved select held, nothing reaches the edge detector
    assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel_i != SEL_PIN0) |=> !($past(pin_gated)));
endmodule

// File: tb/tcs_count_source_test.sv
module tcs_count_source_test;
    localparam int PC_W = 8;
    localparam int TC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_i = 2'b00;
    logic [1:0]      in_sel_i = 2'b00;
    logic [2:0]      cap_ctrl_i = 3'b000;
    logic [PC_W-1:0] prescale_lim_i = '0;
    logic            cap_pin_i = 1'b0;
    logic [PC_W-1:0] pc_o;
    logic [TC_W-1:0] tc_o;
    logic            cfg_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tcs_count_source #(.PC_W(PC_W), .TC_W(TC_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_sel_i(in_sel_i),
        .cap_ctrl_i(cap_ctrl_i), .prescale_lim_i(prescale_lim_i),
        .cap_pin_i(cap_pin_i), .pc_o(pc_o), .tc_o(tc_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string req, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic start(input logic [1:0] m, input logic [1:0] s, input logic [PC_W-1:0] lim);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; in_sel_i = s; cap_ctrl_i = 3'b000;
        prescale_lim_i = lim; cap_pin_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            cap_pin_i = 1'b1;
            repeat (hi) @(negedge clk);
            cap_pin_i = 1'b0;
            repeat (lo) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; mode_i = 2'b00; cap_ctrl_i = 3'b101; prescale_lim_i = 8'd5;
        repeat (3) @(negedge clk);
        check("R1 pc in reset", pc_o, 0);
        check("R1 tc in reset", tc_o, 0);
        check("R1 err in reset", cfg_err_o, 0);
    endtask

    task automatic t_timer();
        start(2'b00, 2'b00, 8'd3);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            check("R2 pc timer", pc_o, n % 4);
            check("R3 tc timer", tc_o, n / 4);
        end
        start(2'b00, 2'b00, 8'd0);
        repeat (6) @(negedge clk);
        check("R3 limit zero tc", tc_o, 6);
        check("R3 limit zero pc", pc_o, 0);
    endtask

    task automatic t_latency();
        start(2'b01, 2'b00, 8'd7);
        repeat (2) @(negedge clk);
        cap_pin_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 tc before third edge", tc_o, 0);
        @(negedge clk);
        check("R4 tc after third edge", tc_o, 1);
        check("R7 pc held in rise mode", pc_o, 0);
    endtask

    task automatic t_modes();
        start(2'b01, 2'b00, 8'd7);
        pulses(4, 3, 3);
        check("R4 rise count", tc_o, 4);
        start(2'b10, 2'b00, 8'd7);
        pulses(4, 3, 3);
        check("R5 fall count", tc_o, 4);
        start(2'b11, 2'b00, 8'd7);
        pulses(4, 3, 3);
        check("R6 both count", tc_o, 8);
        check("R7 pc held in both mode", pc_o, 0);
    endtask

    task automatic t_short();
        start(2'b01, 2'b00, 8'd7);
        pulses(1, 2, 2);
        check("R8 two-period pulse rise", tc_o, 1);
        start(2'b11, 2'b00, 8'd7);
        pulses(3, 2, 2);
        check("R8 two-period pulses both", tc_o, 6);
    endtask

    task automatic t_reserved();
        for (int s = 1; s <= 3; s++) begin
            start(2'b11, 2'(s), 8'd7);
            pulses(3, 3, 3);
            check("R9 reserved select", tc_o, 0);
        end
    endtask

    task automatic t_err();
        @(negedge clk);
        mode_i = 2'b01; cap_ctrl_i = 3'b101; #1;
        check("R10 err rise mode ctrl set", cfg_err_o, 1);
        mode_i = 2'b00; #1;
        check("R10 err timer mode", cfg_err_o, 0);
        mode_i = 2'b11; cap_ctrl_i = 3'b000; #1;
        check("R10 err ctrl clear", cfg_err_o, 0);
        cap_ctrl_i = 3'b100; #1;
        check("R10 err both mode", cfg_err_o, 1);
    endtask

    task automatic t_timer_ignores_pin();
        start(2'b00, 2'b11, 8'd1);
        for (int i = 0; i < 10; i++) begin
            cap_pin_i = ~cap_pin_i;
            in_sel_i = 2'(i);
            @(negedge clk);
        end
        check("R11 tc ignores pin", tc_o, 5);
        check("R11 pc ignores pin", pc_o, 0);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_latency();
        t_modes();
        t_short();
        t_reserved();
        t_err();
        t_timer_ignores_pin();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule